// File: doc/BRIEF.md
# Modem Control Status Scanner

This block manages the modem handshake signals of a bank of serial channels (sixteen by default). For every channel it holds two control outputs (request to send and data terminal ready), a pair of compare enables and a pair of reference bits. It also samples two live input signals per channel: carrier detect and data set ready. A host updates one channel per write, and sees one channel per read through a single status word. Each read moves a channel pointer on by one, so a run of reads walks the whole bank.

A change flag is raised for an input whose sampled level differs from its stored reference while its compare enable is set. When scan mode is on, a small state machine moves the pointer one channel per clock. It stops on the first channel that shows a change, and it raises an interrupt flag that stays set until the host clears it. The host then reads the status word to learn which channel caused the interrupt. The machine has four states. SCAN_OFF: scan mode is off. SCAN_SEEK: the pointer is stepping. SCAN_HELD: a change was found and the flag is set. SCAN_PARK: a full lap found nothing, and the machine waits for an input edge or a write.

The transitions are as follows. Any write goes to SCAN_OFF when its scan bit is clear. When the scan bit is set, a write goes to SCAN_HELD if the flag stays set, and to SCAN_SEEK otherwise. SCAN_SEEK goes to SCAN_HELD on a hit, and to SCAN_PARK after a lap with no hit. SCAN_HELD goes to SCAN_SEEK when the flag is cleared. SCAN_PARK goes to SCAN_SEEK when any sampled input changes.

Top module: `mdm_scan_top`

## Requirements
- R1: After reset, every channel's control, compare-enable, reference and sampled-input bits are 0, scan mode is off, the pointer is 0 and `irq` is 0. The read word is therefore 16'hC000 and `ctl_out` is all zeros.
- R2: A write with bit 14 set updates the channel named in bits 13:10. That channel's compare enables always take bits 3:2 and its reference bits always take bits 1:0. A write with bit 14 clear changes no channel.
- R3: On an updating write, C2 (request to send) takes bit 5 only when bit 7 is set, and C1 (data terminal ready) takes bit 4 only when bit 6 is set. Channel n drives C2 on `ctl_out[2n+1]` and C1 on `ctl_out[2n]`.
- R4: The read word has bits 15:14 = 11, the pointer in bits 13:10, the change flags in bits 9:8, zeros in bits 7:4, the compare enables in bits 3:2 and the sampled inputs in bits 1:0. Bit 1 is carrier detect and bit 0 is data set ready. `line_in[2n+1:2n]` is sampled with one clock of delay.
- R5: Each change flag equals (sampled input XOR reference bit) AND compare enable, bit for bit.
- R6: A cycle with `rd_en` high advances the pointer by one, wrapping from the last channel to 0. A write never moves the pointer.
- R7: Every write sets scan mode from bit 15. With scan mode off, the pointer moves only on reads and `irq` is never set.
- R8: In scan mode with `irq` clear, the pointer steps one channel per clock from the channel after the current one. It stops on the first channel with a nonzero change flag and sets `irq` there. After one full lap with no hit it waits until a sampled input changes or a write arrives.
- R9: `irq` stays set until a cycle with `irq_clr` high. Stepping is suspended while `irq` is set, and clearing `irq` resumes the search.
- R10: On a channel marked in `MODEM_MASK`, a write that takes C1 from 1 to 0 clears that channel's sampled inputs. They stay 0 until both inputs have been seen low. Channels not marked are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write word |
| rd_en | input | 1 | Read strobe; advances the pointer |
| rd_data | output | 16 | Status word for the current pointer |
| irq_clr | input | 1 | Clears the interrupt flag |
| line_in | input | 2*NCH | Per-channel live inputs {carrier, data set ready} |
| ctl_out | output | 2*NCH | Per-channel control outputs {C2, C1} |
| irq | output | 1 | Change interrupt flag |

## Verification
The assertions assume that `line_in` is synchronous to `clk` and that `NCH` is a power of two no larger than sixteen, so that the pointer arithmetic wraps naturally. They also assume that reads and writes are single-cycle strobes. The pointer property depends on reads taking priority over scan stepping, and the flag property depends on `irq_clr` being the only way the flag falls. The bench drives every input on the falling edge and samples on the falling edge. While scan mode is on it never issues reads, so the position of the pointer follows from the requirements alone.

// File: rtl/mdm_scan_pkg.sv
package mdm_scan_pkg;

    localparam int WORD_W  = 16;
    localparam int B_SCAN  = 15;
    localparam int B_UPD   = 14;
    localparam int CH_LSB  = 10;
    localparam int CH_W    = 4;
    localparam int B_EN_C2 = 7;
    localparam int B_EN_C1 = 6;
    localparam int B_C2    = 5;
    localparam int B_C1    = 4;
    localparam int CMP_LSB = 2;
    localparam int REF_LSB = 0;

    typedef enum logic [1:0] {
        SCAN_OFF  = 2'd0,
        SCAN_SEEK = 2'd1,
        SCAN_HELD = 2'd2,
        SCAN_PARK = 2'd3
    } scan_state_e;

    typedef struct packed {
        logic       en_c2;
        logic       en_c1;
        logic       c2;
        logic       c1;
        logic [1:0] cmp;
        logic [1:0] refv;
    } chan_cfg_t;

endpackage

// File: rtl/mdm_chan_bank.sv
module mdm_chan_bank
    import mdm_scan_pkg::*;
#(
    parameter int NCH = 16,
    parameter logic [NCH-1:0] MODEM_MASK = '1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic [$clog2(NCH)-1:0]  upd_ch,
    input  chan_cfg_t               cfg,
    input  logic [2*NCH-1:0]        line_in,
    output logic [2*NCH-1:0]        ctl,
    output logic [2*NCH-1:0]        cmp_en,
    output logic [2*NCH-1:0]        st,
    output logic [2*NCH-1:0]        chg,
    output logic                    st_evt
);

    localparam int CHW = $clog2(NCH);

    logic [NCH-1:0] evt_vec;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [1:0] ctl_q;
        logic [1:0] cmp_q;
        logic [1:0] ref_q;
        logic [1:0] st_q;
        logic       hang_q;
        logic [1:0] pins;
        logic [1:0] st_nxt;
        logic       sel;
        logic       c1_new;
        logic       c2_new;
        logic       drop;

        assign pins   = line_in[2*g +: 2];
        assign sel    = upd && (upd_ch == CHW'(g));
        assign c2_new = cfg.en_c2 ? cfg.c2 : ctl_q[1];
        assign c1_new = cfg.en_c1 ? cfg.c1 : ctl_q[0];
        // a falling data terminal ready on a modem line hangs the channel up
        assign drop   = sel && MODEM_MASK[g] && ctl_q[0] && !c1_new;
        assign st_nxt = (drop || hang_q) ? 2'b00 : pins;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_q  <= '0;
                cmp_q  <= '0;
                ref_q  <= '0;
                st_q   <= '0;
                hang_q <= 1'b0;
            end else begin
                if (sel) begin
                    ctl_q <= {c2_new, c1_new};
                    cmp_q <= cfg.cmp;
                    ref_q <= cfg.refv;
                end
                if (drop) begin
                    hang_q <= 1'b1;
                end else if (pins == 2'b00) begin
                    hang_q <= 1'b0;
                end
                st_q <= st_nxt;
            end
        end

        assign evt_vec[g]      = (st_nxt != st_q);
        assign ctl[2*g +: 2]    = ctl_q;
        assign cmp_en[2*g +: 2] = cmp_q;
        assign st[2*g +: 2]     = st_q;
        assign chg[2*g +: 2]    = (st_q ^ ref_q) & cmp_q;
    end

    assign st_evt = |evt_vec;

endmodule

// File: rtl/mdm_scan_fsm.sv
module mdm_scan_fsm
    import mdm_scan_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_scan,
    input  logic                    rd_en,
    input  logic                    irq_clr,
    input  logic                    st_evt,
    input  logic [2*NCH-1:0]        chg,
    output logic [$clog2(NCH)-1:0]  cur_ch,
    output logic                    irq,
    output logic                    scan_on
);

    localparam int CHW = $clog2(NCH);
    localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

    scan_state_e    state_q, state_d;
    logic [CHW-1:0] cur_q, cur_d;
    logic [CHW-1:0] cnt_q, cnt_d;
    logic [CHW-1:0] nxt_ch;
    logic           flag_q, flag_d;
    logic           scan_q, scan_d;
    logic           step;
    logic           nxt_hot;
    logic           hit;
    logic           lap_end;

    assign nxt_ch  = cur_q + 1'b1;
    assign nxt_hot = |chg[2*nxt_ch +: 2];
    // reads and writes take the cycle; the scan yields to them
    assign step    = (state_q == SCAN_SEEK) && !wr_en && !rd_en;
    assign hit     = step && nxt_hot;
    assign lap_end = step && !nxt_hot && (cnt_q == LAST);

    // next state
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (!wr_scan) begin
                state_d = SCAN_OFF;
            end else if (flag_q && !irq_clr) begin
                state_d = SCAN_HELD;
            end else begin
                state_d = SCAN_SEEK;
            end
        end else begin
            unique case (state_q)
                SCAN_OFF:  state_d = SCAN_OFF;
                SCAN_SEEK: begin
                    if (hit) begin
                        state_d = SCAN_HELD;
                    end else if (lap_end) begin
                        state_d = SCAN_PARK;
                    end
                end
                SCAN_HELD: begin
                    if (irq_clr) begin
                        state_d = SCAN_SEEK;
                    end
                end
                SCAN_PARK: begin
                    if (st_evt) begin
                        state_d = SCAN_SEEK;
                    end
                end
                default:   state_d = SCAN_OFF;
            endcase
        end
    end

    // datapath next values
    always_comb begin
        cur_d  = (rd_en || step) ? nxt_ch : cur_q;
        flag_d = hit ? 1'b1 : (irq_clr ? 1'b0 : flag_q);
        scan_d = wr_en ? wr_scan : scan_q;
        if ((state_q == SCAN_SEEK) && (state_d == SCAN_SEEK) && !wr_en) begin
            cnt_d = step ? cnt_q + 1'b1 : cnt_q;
        end else begin
            cnt_d = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SCAN_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            cnt_q  <= '0;
            flag_q <= 1'b0;
            scan_q <= 1'b0;
        end else begin
            cur_q  <= cur_d;
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
            scan_q <= scan_d;
        end
    end

    // outputs
    always_comb begin
        cur_ch  = cur_q;
        irq     = flag_q;
        scan_on = scan_q;
    end

endmodule

// File: rtl/mdm_scan_top.sv
module mdm_scan_top
    import mdm_scan_pkg::*;
#(
    parameter int NCH = 16,
    parameter logic [NCH-1:0] MODEM_MASK = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                rd_en,
    output logic [WORD_W-1:0]   rd_data,
    input  logic                irq_clr,
    input  logic [2*NCH-1:0]    line_in,
    output logic [2*NCH-1:0]    ctl_out,
    output logic                irq
);

    localparam int CHW = $clog2(NCH);

    chan_cfg_t        cfg;
    logic [CHW-1:0]   cur_ch;
    logic [2*NCH-1:0] cmp_vec;
    logic [2*NCH-1:0] st_vec;
    logic [2*NCH-1:0] chg_vec;
    logic             st_evt;
    logic             scan_on;
    logic             upd;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[9:8], wr_data[CH_LSB+CH_W-1:CH_LSB]};

    assign upd = wr_en && wr_data[B_UPD];
    assign cfg = '{
        en_c2: wr_data[B_EN_C2],
        en_c1: wr_data[B_EN_C1],
        c2:    wr_data[B_C2],
        c1:    wr_data[B_C1],
        cmp:   wr_data[CMP_LSB +: 2],
        refv:  wr_data[REF_LSB +: 2]
    };

    mdm_chan_bank #(
        .NCH        (NCH),
        .MODEM_MASK (MODEM_MASK)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .upd_ch  (wr_data[CH_LSB +: CHW]),
        .cfg     (cfg),
        .line_in (line_in),
        .ctl     (ctl_out),
        .cmp_en  (cmp_vec),
        .st      (st_vec),
        .chg     (chg_vec),
        .st_evt  (st_evt)
    );

    mdm_scan_fsm #(
        .NCH (NCH)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_scan (wr_data[B_SCAN]),
        .rd_en   (rd_en),
        .irq_clr (irq_clr),
        .st_evt  (st_evt),
        .chg     (chg_vec),
        .cur_ch  (cur_ch),
        .irq     (irq),
        .scan_on (scan_on)
    );

    assign rd_data = {2'b11, CH_W'(cur_ch), chg_vec[2*cur_ch +: 2], 4'b0000,
                      cmp_vec[2*cur_ch +: 2], st_vec[2*cur_ch +: 2]};

endmodule

// File: rtl/mdm_scan_chk.sv
module mdm_scan_chk #(
    parameter int NCH = 16,
    parameter logic [NCH-1:0] MODEM_MASK = '1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic                   wr_upd,
    input logic [$clog2(NCH)-1:0] wr_ch,
    input logic                   wr_en_c2,
    input logic                   wr_en_c1,
    input logic                   wr_c1,
    input logic                   rd_en,
    input logic [$clog2(NCH)-1:0] rd_ch,
    input logic                   irq_clr,
    input logic                   irq,
    input logic                   scan_on,
    input logic [2*NCH-1:0]       ctl_out,
    input logic [2*NCH-1:0]       st
);

    localparam int CHW = $clog2(NCH);

    logic           drop_q;
    logic           gate_q;
    logic           c2_prev;
    logic [CHW-1:0] ch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drop_q  <= 1'b0;
            gate_q  <= 1'b0;
            c2_prev <= 1'b0;
            ch_q    <= '0;
        end else begin
            drop_q  <= wr_en && wr_upd && wr_en_c1 && !wr_c1 &&
                       ctl_out[2*wr_ch] && MODEM_MASK[wr_ch];
            gate_q  <= wr_en && wr_upd && !wr_en_c2;
            c2_prev <= ctl_out[2*wr_ch+1];
            ch_q    <= wr_ch;
        end
    end

    assert_ctl_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> (ctl_out[2*ch_q+1] == c2_prev));

    assert_read_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_ch == CHW'($past(rd_ch) + 1'b1)));

    assert_quiet_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_on && !irq) |=> !irq);

    assert_hit_in_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> scan_on);

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    assert_dtr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drop_q |-> (st[2*ch_q +: 2] == 2'b00));

endmodule

bind mdm_scan_top mdm_scan_chk #(
    .NCH        (NCH),
    .MODEM_MASK (MODEM_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_upd   (wr_data[14]),
    .wr_ch    (wr_data[10 +: $clog2(NCH)]),
    .wr_en_c2 (wr_data[7]),
    .wr_en_c1 (wr_data[6]),
    .wr_c1    (wr_data[4]),
    .rd_en    (rd_en),
    .rd_ch    (rd_data[10 +: $clog2(NCH)]),
    .irq_clr  (irq_clr),
    .irq      (irq),
    .scan_on  (scan_on),
    .ctl_out  (ctl_out),
    .st       (st_vec)
);

// File: tb/tb_mdm_scan_top.sv
`timescale 1ns/1ps
module tb_mdm_scan_top;

    localparam int NCH = 16;
    localparam logic [NCH-1:0] MMASK = 16'h00FF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [15:0]     wr_data = '0;
    logic            rd_en = 1'b0;
    logic [15:0]     rd_data;
    logic            irq_clr = 1'b0;
    logic [2*NCH-1:0] line_in = '0;
    logic [2*NCH-1:0] ctl_out;
    logic            irq;

    int nchk = 0;
    int nerr = 0;
    int tb_ptr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mdm_scan_top #(.NCH(NCH), .MODEM_MASK(MMASK)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irq_clr(irq_clr),
        .line_in(line_in), .ctl_out(ctl_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] w);
        wr_data = w;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic rd(output logic [15:0] w);
        w = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        tb_ptr = (tb_ptr + 1) % NCH;
    endtask

    task automatic peek(input int ch, output logic [15:0] w);
        logic [15:0] tmp;
        while (tb_ptr != ch) rd(tmp);
        rd(w);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [15:0] cfgw(int ch, int e2, int e1, int c2, int c1);
        return 16'((1 << 14) | (ch << 10) | (e2 << 7) | (e1 << 6) | (c2 << 5) |
                   (c1 << 4) | (((ch >> 2) & 3) << 2) | (ch & 3));
    endfunction

    function automatic logic [15:0] expw(int ch, int en, int rf, int s);
        return 16'(16'hC000 | (ch << 10) | ((((s ^ rf) & en)) << 8) | (en << 2) | s);
    endfunction

    task automatic set_lines(input int p);
        for (int ch = 0; ch < NCH; ch++) line_in[2*ch +: 2] = 2'((ch * 3 + p) & 3);
        @(negedge clk);
    endtask

    task automatic sweep(input int p, input string req);
        logic [15:0] w;
        for (int ch = 0; ch < NCH; ch++) begin
            peek(ch, w);
            chk(req, w, expw(ch, (ch >> 2) & 3, ch & 3, (ch * 3 + p) & 3));
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic [2*NCH-1:0] exp_ctl;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 word", rd_data, 16'hC000);
        chk("R1 irq", irq, 0);
        chk("R1 ctl", ctl_out, 0);
        for (int ch = 0; ch < NCH; ch++) begin
            rd(w);
            chk("R1 R6 reset sweep", w, 16'(16'hC000 | (ch << 10)));
        end
        chk("R6 wrap to 0", rd_data[13:10], 0);

        // R2 R3 configure every channel, both controls on
        for (int ch = 0; ch < NCH; ch++) wr(cfgw(ch, 1, 1, 1, 1));
        chk("R3 ctl all set", ctl_out, {2*NCH{1'b1}});

        set_lines(0);
        sweep(0, "R4 R5 pattern0");

        // R2 write without update bit changes nothing
        wr(16'h00FF);
        set_lines(1);
        sweep(1, "R2 R5 pattern1");
        chk("R2 ctl kept", ctl_out, {2*NCH{1'b1}});

        // R3 enables off: controls held
        for (int ch = 0; ch < NCH; ch++) wr(cfgw(ch, 0, 0, 0, 0));
        chk("R3 ctl held", ctl_out, {2*NCH{1'b1}});

        // R3 C2 cleared on even channels only
        for (int ch = 0; ch < NCH; ch += 2) wr(cfgw(ch, 1, 0, 0, 0));
        exp_ctl = '0;
        for (int ch = 0; ch < NCH; ch++) exp_ctl[2*ch +: 2] = {ch[0], 1'b1};
        chk("R3 C2 gated", ctl_out, exp_ctl);

        set_lines(2);
        sweep(2, "R5 pattern2");

        // R10 hangup on modem channel 5, none on channel 12
        line_in = '0;
        line_in[2*5 +: 2] = 2'b11;
        line_in[2*12 +: 2] = 2'b11;
        @(negedge clk);
        wr(16'((1 << 14) | (5 << 10) | (1 << 6)));
        wr(16'((1 << 14) | (12 << 10) | (1 << 6)));
        chk("R10 C1 dropped", {ctl_out[2*12], ctl_out[2*5]}, 2'b00);
        peek(5, w);
        chk("R10 modem cleared", w[1:0], 2'b00);
        peek(12, w);
        chk("R10 plain line kept", w[1:0], 2'b11);
        idle(5);
        peek(5, w);
        chk("R10 still hung", w[1:0], 2'b00);
        line_in[2*5 +: 2] = 2'b00;
        idle(2);
        line_in[2*5 +: 2] = 2'b11;
        idle(2);
        peek(5, w);
        chk("R10 released", w[1:0], 2'b11);

        // clear all channels for scan tests
        line_in = '0;
        for (int ch = 0; ch < NCH; ch++) wr(16'((1 << 14) | (ch << 10)));
        idle(2);

        // R8 scan finds channel 9
        line_in[2*9] = 1'b1;
        @(negedge clk);
        wr(16'((1 << 15) | (1 << 14) | (9 << 10) | (1 << 2)));
        idle(20);
        chk("R8 irq set", irq, 1);
        chk("R8 stop channel", rd_data[13:8], {4'd9, 2'b01});
        tb_ptr = 9;

        // R9 flag holds, clear resumes and refinds after a lap
        idle(5);
        chk("R9 held", {irq, rd_data[13:10]}, {1'b1, 4'd9});
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R9 cleared", irq, 0);
        idle(20);
        chk("R9 refound", {irq, rd_data[13:10]}, {1'b1, 4'd9});

        // R7 scan off: no interrupt, pointer frozen
        wr(16'h0000);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        idle(30);
        chk("R7 off no irq", irq, 0);
        chk("R7 pointer frozen", rd_data[13:10], 9);

        // R8 park with nothing to find, wake on input edge
        wr(16'((1 << 15) | (1 << 14) | (9 << 10)));
        idle(40);
        chk("R8 park no irq", irq, 0);
        wr(16'((1 << 15) | (1 << 14) | (3 << 10) | (2 << 2)));
        idle(40);
        chk("R8 still parked", irq, 0);
        line_in[2*3+1] = 1'b1;
        idle(22);
        chk("R8 wake irq", irq, 1);
        chk("R8 wake channel", rd_data[13:8], {4'd3, 2'b10});

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule